// File: doc/BRIEF.md
# Prescaled Input Glitch Filter

This block cleans up one asynchronous digital input before anything downstream looks for edges on it. The raw pin is first brought into the system clock domain by a two-stage synchronizer. A free-running prescaler then produces a sample strobe every P system clocks, where P is a power of two chosen by a 3-bit code and a range-select bit. A mode selector decides how the samples are turned into a clean level. Continuous mode copies the synchronized input straight through. Two-sample mode needs two consecutive agreeing samples before the level changes. Three-sample mode needs three. Integrator mode uses a 2-bit saturating up/down counter.

Integrator mode is allowed only on an instance whose integrator strap is tied high, which is the instance that filters a time-base clock input. A share-override input forces the prescaler into its slower range. Use it when the filter clock is shared with the channel filters. Besides the filtered level, the block gives one-clock rising-edge and falling-edge pulses.

Top module: `pgf_top`

## Requirements
- R1: While reset is asserted and right after its release, `level_o`, `rise_o` and `fall_o` are 0. With the pin held low after reset, no edge pulse appears.
- R2: Mode code 00 (continuous) has no sampling. `level_o` takes a new pin value on the 3rd rising clock edge after the pin changes. A pulse one clock wide is passed.
- R3: Mode code 01 (two-sample) updates the level only when two consecutive samples agree and differ from it. With P=1 the level changes on the 4th clock edge after the pin changes. A pulse of 2P clocks or longer is always passed. A pulse of P clocks or shorter is always rejected.
- R4: Mode code 10 (three-sample) needs three consecutive agreeing samples. With P=1 the level changes on the 5th edge. A pulse of 3P clocks or longer is always passed. A pulse of 2P clocks or shorter is always rejected.
- R5: Mode code 11 with the integrator strap at 1 uses a 2-bit saturating counter. The counter steps up on a high sample and down on a low one. The level goes to 1 when the counter reaches 3 and to 0 when it reaches 0. The latency and the pass/reject widths match R4. The sample sequence 1,1,0,1,1 raises the level.
- R6: Mode code 11 with the integrator strap at 0 behaves exactly as three-sample mode.
- R7: With the range-select bit at 1, prescale codes 0..7 give P = 1, 2, 4 … 128 clocks. With the bit at 0, they give P = 2, 4 … 256 clocks. Outside continuous mode the level changes only on a sample strobe.
- R8: While the share-override input is 1, P follows the range-select-0 mapping whatever the range-select bit holds.
- R9: Every change of `level_o` gives exactly one pulse, one clock wide, on `rise_o` (0 to 1) or `fall_o` (1 to 0). The pulse appears in the same cycle as the new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw asynchronous input |
| presc_code_i | input | 3 | Prescale exponent code |
| fast_src_i | input | 1 | Range select: 1 gives P=2^code, 0 gives P=2^(code+1) |
| share_ovr_i | input | 1 | Forces the range-select-0 mapping |
| mode_i | input | 2 | 00 continuous, 01 two-sample, 10 three-sample, 11 integrator |
| integ_en_i | input | 1 | Strap that permits integrator mode |
| level_o | output | 1 | Filtered level |
| rise_o | output | 1 | One-clock pulse on a rising filtered edge |
| fall_o | output | 1 | One-clock pulse on a falling filtered edge |

## Verification
The bench first steps the pin once in each mode at P=1 and times the level change edge by edge. This separates the 3, 4 and 5 edge pipelines and checks the edge pulses in the same pass. It then drives single pulses of exactly the guaranteed reject width and the guaranteed pass width, for several prescale settings. These pulses show whether the sample spacing matches the code mapping, the range bit and the share override. A 1,1,0,1,1 pattern tells the integrator apart from three-sample mode. The same pattern also shows that a cleared strap falls back to three-sample behaviour.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
  typedef enum logic [1:0] {
    FM_CONT  = 2'b00,
    FM_TWO   = 2'b01,
    FM_THREE = 2'b10,
    FM_INTEG = 2'b11
  } fmode_e;
endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q, ff_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb ff_d = d_i;
    end else begin : g_chain
      always_comb ff_d = {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= ff_d;
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/pgf_presc.sv
module pgf_presc #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              fast_src_i,
  input  logic              share_ovr_i,
  output logic              tick_o
);
  localparam int CNT_W = 1 << CODE_W;
  localparam int SH_W  = $clog2(CNT_W + 1);
  localparam logic [CNT_W:0] ONE = 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SH_W-1:0]  shift;
  logic [CNT_W:0]   mask;
  logic             single;

  always_comb begin
    single = fast_src_i && !share_ovr_i;
    if (single) shift = SH_W'(code_i);
    else        shift = SH_W'(code_i) + SH_W'(1);
    mask  = (ONE << shift) - ONE;
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q & mask[CNT_W-1:0]) == mask[CNT_W-1:0];

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !(single && code_i == '0)) |=> !tick_o); // R7
endmodule

// File: rtl/pgf_core.sv
module pgf_core
  import pgf_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   smp_i,
  input  fmode_e mode_i,
  output logic   level_o
);
  localparam int HIST_W = 2;
  localparam logic [1:0] CNT_MAX = 2'd3;

  logic [HIST_W-1:0] hist_q, hist_d;
  logic [1:0]        icnt_q, icnt_d;
  logic              lvl_q, lvl_d;

  always_comb begin
    hist_d = hist_q;
    icnt_d = icnt_q;
    lvl_d  = lvl_q;
    if (tick_i) begin
      hist_d = {hist_q[HIST_W-2:0], smp_i};
      if (smp_i && icnt_q != CNT_MAX)   icnt_d = icnt_q + 2'd1;
      else if (!smp_i && icnt_q != 2'd0) icnt_d = icnt_q - 2'd1;
    end
    unique case (mode_i)
      FM_CONT:  lvl_d = smp_i;
      FM_TWO:   if (tick_i && smp_i == hist_q[0]) lvl_d = smp_i;
      FM_THREE: if (tick_i && smp_i == hist_q[0] && smp_i == hist_q[1]) lvl_d = smp_i;
      FM_INTEG: begin
        if (tick_i) begin
          if (icnt_d == CNT_MAX)  lvl_d = 1'b1;
          else if (icnt_d == 2'd0) lvl_d = 1'b0;
        end
      end
      default:  lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      icnt_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      icnt_q <= icnt_d;
      lvl_q  <= lvl_d;
    end
  end

  assign level_o = lvl_q;

  AST_HOLD_OFF_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && mode_i != FM_CONT) |=> $stable(lvl_q)); // R7
  AST_TWO_NEED_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FM_TWO && tick_i && smp_i != hist_q[0]) |=> $stable(lvl_q)); // R3
  AST_THREE_NEED_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FM_THREE && tick_i && smp_i != hist_q[1]) |=> $stable(lvl_q)); // R4
  AST_INTEG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == FM_INTEG && tick_i && smp_i && icnt_q == 2'd2) |=> lvl_q); // R5
endmodule

// File: rtl/pgf_edge.sv
module pgf_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R9
  AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o); // R9
endmodule

// File: rtl/pgf_top.sv
module pgf_top
  import pgf_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [CODE_W-1:0] presc_code_i,
  input  logic              fast_src_i,
  input  logic              share_ovr_i,
  input  logic [1:0]        mode_i,
  input  logic              integ_en_i,
  output logic              level_o,
  output logic              rise_o,
  output logic              fall_o
);
  logic   smp, tick;
  fmode_e mode_eff;

  always_comb begin
    mode_eff = fmode_e'(mode_i);
    if (mode_eff == FM_INTEG && !integ_en_i) mode_eff = FM_THREE;
  end

  pgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(smp)
  );

  pgf_presc #(.CODE_W(CODE_W)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(presc_code_i),
    .fast_src_i(fast_src_i), .share_ovr_i(share_ovr_i), .tick_o(tick)
  );

  pgf_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .smp_i(smp),
    .mode_i(mode_eff), .level_o(level_o)
  );

  pgf_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level_o),
    .rise_o(rise_o), .fall_o(fall_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!level_o && !rise_o && !fall_o)); // R1
endmodule

// File: tb/pgf_top_test.sv
module pgf_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic [2:0] code = 3'd0;
  logic       fast = 1'b1;
  logic       shr = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       integ = 1'b0;
  logic       level, rise, fall;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pgf_top uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .presc_code_i(code),
    .fast_src_i(fast), .share_ovr_i(shr), .mode_i(mode), .integ_en_i(integ),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [2:0] c, input logic f,
                          input logic s, input logic ie);
    @(negedge clk);
    rst_n = 1'b0; pin = 1'b0; mode = m; code = c; fast = f; shr = s; integ = ie;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
  endtask

  // R1: reset state and quiet output with a low pin
  task automatic t_reset();
    int pulses = 0;
    @(negedge clk);
    rst_n = 1'b0; pin = 1'b1; mode = 2'b00;
    cyc(2);
    chk(level == 0 && rise == 0 && fall == 0, "R1 in reset", {level, rise, fall}, 0);
    pin = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      pulses += rise + fall + level;
    end
    chk(pulses == 0, "R1 after release", pulses, 0);
  endtask

  // R2/R3/R4/R5 latency at P=1, R9 edge pulses
  task automatic t_latency(input logic [1:0] m, input logic ie, input int n, input string tag);
    do_reset(m, 3'd0, 1'b1, 1'b0, ie);
    pin = 1'b1;
    cyc(n - 1);
    chk(level == 0 && rise == 0, {tag, " before rise"}, level, 0);
    cyc(1);
    chk(level == 1, {tag, " rise latency"}, level, 1);
    chk(rise == 1 && fall == 0, "R9 rise pulse", {rise, fall}, 2);
    cyc(1);
    chk(rise == 0 && level == 1, "R9 rise one cycle", rise, 0);
    cyc(8);
    pin = 1'b0;
    cyc(n - 1);
    chk(level == 1 && fall == 0, {tag, " before fall"}, level, 1);
    cyc(1);
    chk(level == 0 && fall == 1 && rise == 0, {tag, " fall latency R9"}, {level, fall, rise}, 2);
    cyc(1);
    chk(fall == 0, "R9 fall one cycle", fall, 0);
  endtask

  // pulse of w clocks; pass expects one rise and one fall, reject expects none
  task automatic t_pulse(input logic [1:0] m, input logic [2:0] c, input logic f,
                         input logic s, input logic ie, input int w, input bit pass,
                         input string tag);
    int p, rises = 0, falls = 0;
    p = (f && !s) ? (1 << c) : (2 << c);
    do_reset(m, c, f, s, ie);
    pin = 1'b1;
    for (int i = 0; i < w + 3 * p + 12; i++) begin
      cyc(1);
      rises += rise;
      falls += fall;
      if (i == w - 1) pin = 1'b0;
    end
    if (pass) chk(rises == 1 && falls == 1, {tag, " pass"}, rises * 10 + falls, 11);
    else      chk(rises == 0 && falls == 0, {tag, " reject"}, rises * 10 + falls, 0);
  endtask

  // sample pattern 1,1,0,1,1 then low at P=1
  task automatic t_pattern(input logic [1:0] m, input logic ie, input int exp_rises,
                           input string tag);
    bit pat [5] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    int rises = 0;
    do_reset(m, 3'd0, 1'b1, 1'b0, ie);
    for (int i = 0; i < 25; i++) begin
      pin = (i < 5) ? pat[i] : 1'b0;
      cyc(1);
      rises += rise;
    end
    chk(rises == exp_rises, tag, rises, exp_rises);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_latency(2'b00, 1'b0, 3, "R2");
    t_latency(2'b01, 1'b0, 4, "R3");
    t_latency(2'b10, 1'b0, 5, "R4");
    t_latency(2'b11, 1'b1, 5, "R5");
    t_pulse(2'b00, 3'd0, 1'b1, 1'b0, 1'b0, 1, 1'b1, "R2 one-clock");
    t_pulse(2'b01, 3'd0, 1'b1, 1'b0, 1'b0, 1, 1'b0, "R3 P=1 w1");
    t_pulse(2'b01, 3'd0, 1'b1, 1'b0, 1'b0, 2, 1'b1, "R3 P=1 w2");
    t_pulse(2'b10, 3'd0, 1'b1, 1'b0, 1'b0, 2, 1'b0, "R4 P=1 w2");
    t_pulse(2'b10, 3'd0, 1'b1, 1'b0, 1'b0, 3, 1'b1, "R4 P=1 w3");
    t_pulse(2'b11, 3'd0, 1'b1, 1'b0, 1'b1, 2, 1'b0, "R5 P=1 w2");
    t_pulse(2'b11, 3'd0, 1'b1, 1'b0, 1'b1, 3, 1'b1, "R5 P=1 w3");
    t_pulse(2'b01, 3'd2, 1'b1, 1'b0, 1'b0, 4, 1'b0, "R7 fast P=4 w4");
    t_pulse(2'b01, 3'd2, 1'b1, 1'b0, 1'b0, 8, 1'b1, "R7 fast P=4 w8");
    t_pulse(2'b01, 3'd2, 1'b0, 1'b0, 1'b0, 8, 1'b0, "R7 slow P=8 w8");
    t_pulse(2'b01, 3'd2, 1'b0, 1'b0, 1'b0, 16, 1'b1, "R7 slow P=8 w16");
    t_pulse(2'b10, 3'd3, 1'b1, 1'b0, 1'b0, 16, 1'b0, "R7 R4 P=8 w16");
    t_pulse(2'b10, 3'd3, 1'b1, 1'b0, 1'b0, 24, 1'b1, "R7 R4 P=8 w24");
    t_pulse(2'b01, 3'd7, 1'b0, 1'b0, 1'b0, 256, 1'b0, "R7 P=256 w256");
    t_pulse(2'b01, 3'd7, 1'b0, 1'b0, 1'b0, 512, 1'b1, "R7 P=256 w512");
    t_pulse(2'b01, 3'd2, 1'b1, 1'b1, 1'b0, 8, 1'b0, "R8 override w8");
    t_pulse(2'b01, 3'd2, 1'b1, 1'b1, 1'b0, 16, 1'b1, "R8 override w16");
    t_pattern(2'b11, 1'b1, 1, "R5 integrator pattern");
    t_pattern(2'b10, 1'b0, 0, "R4 three-sample pattern");
    t_pattern(2'b11, 1'b0, 0, "R6 strap low pattern");
    t_pulse(2'b11, 3'd0, 1'b1, 1'b0, 1'b0, 2, 1'b0, "R6 strap low w2");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule